// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Sequencer

The block sits between an interrupt priority encoder and a small CPU core model. While idle, it compares the pending 3-bit request level with the priority mask held in the status register. A request above the mask starts an exception entry sequence. That sequence runs an acknowledge step, updates the status register, builds an autovector, and pushes an 8-byte frame onto the supervisor stack through a 16-bit memory port. It then reads the 32-bit handler address from the vector table and hands it to the core with a one-cycle done pulse.

The core supplies the current status register, the address of the next instruction and the supervisor stack pointer. The core applies the new status register when `sr_we_o` pulses. It takes the new program counter and stack pointer when `done_o` pulses. Memory reads return data one cycle after the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a request is accepted only when `irq_level_i` is strictly greater than the mask in `sr_i[10:8]`. Level 0 means no request. A request that is not accepted produces no acknowledge, no memory access and no busy indication.
- R2: One cycle after acceptance, `ack_o` is high for exactly one cycle. During that cycle `mem_addr_o[3:1]` carries the accepted level and all other address bits are zero.
- R3: During the acknowledge cycle, `sr_we_o` pulses and `sr_new_o` is the status register captured at acceptance, with these changes: bit 13 (supervisor) is set, bit 15 (trace) is cleared, and bits 10:8 hold the accepted level when `mask_ctl_i` was 1 at acceptance, or 7 when it was 0. All other bits are unchanged.
- R4: The status register word placed on the stack is the value captured at acceptance, before any change. It is stored at SP-8.
- R5: The frame is written in cycles 2 to 5 after acceptance, one word per cycle, with the stack pointer decremented by 2 before each write. The order is: the format word at SP-2, PC bits 15:0 at SP-4, PC bits 31:16 at SP-6, and the saved status register at SP-8. The format word is the vector number times 4 in bits 11:0, with bits 15:12 zero. Writes and reads are word-aligned, and the write, read and acknowledge strobes are never high together.
- R6: The vector number is 24 plus the level. The handler address is read as two words: the high half at vector number times 4, in cycle 6, and the low half at that address plus 2, in cycle 7.
- R7: `done_o` is high for exactly one cycle, 9 cycles after acceptance. In that cycle `pc_new_o` is {high word, low word} and `sp_new_o` is SP-8.
- R8: While a sequence is running (`busy_o` high in cycles 1 to 9), `irq_level_i` is ignored, and a request still pending afterwards is not acknowledged a second time in that window.
- R9: A level-7 request is masked like any other level: with a mask of 7 it is not accepted.
- R10: After reset, and after a reset asserted in the middle of a sequence, `busy_o`, `ack_o`, `sr_we_o`, `mem_we_o`, `mem_re_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_level_i | input | 3 | Pending request level, 0 = none |
| mask_ctl_i | input | 1 | 1: new mask = accepted level; 0: new mask = 7 |
| sr_i | input | 16 | Current status register |
| pc_next_i | input | 32 | Address of the next instruction |
| sp_i | input | 32 | Current supervisor stack pointer |
| mem_rdata_i | input | 16 | Read data, valid one cycle after `mem_re_o` |
| busy_o | output | 1 | Sequence running |
| ack_o | output | 1 | Acknowledge cycle indicator |
| sr_we_o | output | 1 | Status register update strobe |
| sr_new_o | output | 16 | Updated status register |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_re_o | output | 1 | Memory word read strobe |
| mem_addr_o | output | 32 | Byte address, also carries the acknowledged level |
| mem_wdata_o | output | 16 | Write data |
| done_o | output | 1 | Handler address loaded |
| pc_new_o | output | 32 | Handler address |
| sp_new_o | output | 32 | Stack pointer after the frame |

## Verification
The bench drives inputs on falling edges and treats the rising edge that accepts a request as cycle 0. It then samples on each following falling edge. The acknowledge and status update fall in cycle 1, the four frame writes in cycles 2 to 5, the vector reads in cycles 6 and 7, and the done pulse with the handler address and stack pointer in cycle 9. Each result is checked against the cycle number at which it appears, not merely its eventual presence, so a shifted or missing stage is reported. Rejected requests are watched over the same 12-cycle window for any strobe.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int SR_T_BIT = 15;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_LSB = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_IACK, S_PFMT, S_PPCL, S_PPCH, S_PSR, S_RDHI, S_RDLO, S_VLD, S_DONE
  } seq_state_e;
endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int LW = 3
) (
  input  logic          idle_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] mask_i,
  output logic          accept_o
);
  // strictly above mask; level 0 can never pass
  assign accept_o = idle_i && (level_i > mask_i);
endmodule

// File: rtl/irq_frame_gen.sv
module irq_frame_gen
  import irq_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 16,
  parameter int LW       = 3,
  parameter int VEC_BASE = 24,
  parameter logic [AW-1:0] VBR = '0
) (
  input  logic [LW-1:0] lvl_i,
  input  logic          im_i,
  input  logic [DW-1:0] sr_saved_i,
  output logic [DW-1:0] sr_new_o,
  output logic [DW-1:0] fmt_word_o,
  output logic [AW-1:0] vec_addr_o
);
  localparam int VNW = 8;

  logic [VNW-1:0] vec_num;

  assign vec_num    = VNW'(VEC_BASE) + VNW'(lvl_i);
  assign fmt_word_o = {{(DW-VNW-2){1'b0}}, vec_num, 2'b00};
  assign vec_addr_o = VBR + {{(AW-VNW-2){1'b0}}, vec_num, 2'b00};

  always_comb begin
    sr_new_o                  = sr_saved_i;
    sr_new_o[SR_T_BIT]        = 1'b0;
    sr_new_o[SR_S_BIT]        = 1'b1;
    sr_new_o[SR_M_LSB +: LW]  = im_i ? lvl_i : '1;
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LW-1:0]   lvl_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [DW-1:0]   sr_saved_i,
  input  logic [DW-1:0]   fmt_word_i,
  input  logic [AW-1:0]   vec_addr_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            idle_o,
  output logic            ack_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            done_o,
  output logic [2*DW-1:0] pc_new_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  seq_state_e      state_q, state_d;
  logic [DW-1:0]   hi_q;
  logic [2*DW-1:0] vec_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_IACK;
      S_IACK: state_d = S_PFMT;
      S_PFMT: state_d = S_PPCL;
      S_PPCL: state_d = S_PPCH;
      S_PPCH: state_d = S_PSR;
      S_PSR:  state_d = S_RDHI;
      S_RDHI: state_d = S_RDLO;
      S_RDLO: state_d = S_VLD;
      S_VLD:  state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hi_q    <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      // read data arrives one cycle after the strobe
      if (state_q == S_RDLO) hi_q <= mem_rdata_i;
      if (state_q == S_VLD)  vec_q <= {hi_q, mem_rdata_i};
    end
  end

  always_comb begin
    ack_o       = 1'b0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_IACK: begin
        ack_o      = 1'b1;
        mem_addr_o = {{(AW-LW-1){1'b0}}, lvl_i, 1'b0};
      end
      S_PFMT: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - STEP;
        mem_wdata_o = fmt_word_i;
      end
      S_PPCL: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - 2 * STEP;
        mem_wdata_o = pc_i[DW-1:0];
      end
      S_PPCH: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - 3 * STEP;
        mem_wdata_o = pc_i[2*DW-1:DW];
      end
      S_PSR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_i - 4 * STEP;
        mem_wdata_o = sr_saved_i;
      end
      S_RDHI: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_addr_i;
      end
      S_RDLO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_addr_i + STEP;
      end
      default: ;
    endcase
  end

  assign idle_o   = (state_q == S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign pc_new_o = vec_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 16,
  parameter int LW       = 3,
  parameter int VEC_BASE = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LW-1:0]   irq_level_i,
  input  logic            mask_ctl_i,
  input  logic [DW-1:0]   sr_i,
  input  logic [2*DW-1:0] pc_next_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            ack_o,
  output logic            sr_we_o,
  output logic [DW-1:0]   sr_new_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            done_o,
  output logic [2*DW-1:0] pc_new_o,
  output logic [AW-1:0]   sp_new_o
);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(4 * (DW / 8));

  logic            idle, accept;
  logic [LW-1:0]   lvl_q;
  logic            im_q;
  logic [DW-1:0]   sr_q;
  logic [2*DW-1:0] pc_q;
  logic [AW-1:0]   sp_q;
  logic [DW-1:0]   fmt_word;
  logic [AW-1:0]   vec_addr;

  irq_accept #(.LW(LW)) u_accept (
    .idle_i   (idle),
    .level_i  (irq_level_i),
    .mask_i   (sr_i[SR_M_LSB +: LW]),
    .accept_o (accept)
  );

  // context frozen at acceptance, before any status change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      im_q  <= 1'b0;
      sr_q  <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
    end else if (accept) begin
      lvl_q <= irq_level_i;
      im_q  <= mask_ctl_i;
      sr_q  <= sr_i;
      pc_q  <= pc_next_i;
      sp_q  <= sp_i;
    end
  end

  irq_frame_gen #(
    .AW(AW), .DW(DW), .LW(LW), .VEC_BASE(VEC_BASE), .VBR('0)
  ) u_frame (
    .lvl_i      (lvl_q),
    .im_i       (im_q),
    .sr_saved_i (sr_q),
    .sr_new_o   (sr_new_o),
    .fmt_word_o (fmt_word),
    .vec_addr_o (vec_addr)
  );

  irq_seq_fsm #(.AW(AW), .DW(DW), .LW(LW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .lvl_i       (lvl_q),
    .sp_i        (sp_q),
    .pc_i        (pc_q),
    .sr_saved_i  (sr_q),
    .fmt_word_i  (fmt_word),
    .vec_addr_i  (vec_addr),
    .mem_rdata_i (mem_rdata_i),
    .idle_o      (idle),
    .ack_o       (ack_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .pc_new_o    (pc_new_o)
  );

  assign busy_o   = !idle;
  assign sr_we_o  = ack_o;
  assign sp_new_o = sp_q - FRAME_BYTES;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int LW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [LW-1:0] irq_level_i,
  input logic [LW-1:0] sr_mask_i,
  input logic          mask_ctl_i,
  input logic          busy_o,
  input logic          ack_o,
  input logic          sr_we_o,
  input logic          sr_t_i,
  input logic          sr_s_i,
  input logic [LW-1:0] sr_new_mask_i,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          addr_lsb_i,
  input logic          done_o
);
  AST_ACK_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(irq_level_i) > $past(sr_mask_i)));  // R1
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R2
  AST_SR_ENTRY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> (sr_s_i && !sr_t_i));  // R3
  AST_SR_NEW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> (sr_new_mask_i == ($past(mask_ctl_i) ? $past(irq_level_i) : '1)));  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o, ack_o}));  // R5
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> !addr_lsb_i);  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_ACK_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !$past(busy_o));  // R8
endmodule

bind irq_entry_seq irq_entry_chk #(.LW(LW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_level_i   (irq_level_i),
  .sr_mask_i     (sr_i[irq_entry_pkg::SR_M_LSB +: LW]),
  .mask_ctl_i    (mask_ctl_i),
  .busy_o        (busy_o),
  .ack_o         (ack_o),
  .sr_we_o       (sr_we_o),
  .sr_t_i        (sr_new_o[irq_entry_pkg::SR_T_BIT]),
  .sr_s_i        (sr_new_o[irq_entry_pkg::SR_S_BIT]),
  .sr_new_mask_i (sr_new_o[irq_entry_pkg::SR_M_LSB +: LW]),
  .mem_we_o      (mem_we_o),
  .mem_re_o      (mem_re_o),
  .addr_lsb_i    (mem_addr_o[0]),
  .done_o        (done_o)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_level_i = '0;
  logic        mask_ctl_i = 1'b0;
  logic [15:0] sr_i = '0;
  logic [31:0] pc_next_i = '0;
  logic [31:0] sp_i = '0;
  logic [15:0] mem_rdata_i;
  logic        busy_o, ack_o, sr_we_o, mem_we_o, mem_re_o, done_o;
  logic [15:0] sr_new_o, mem_wdata_o;
  logic [31:0] mem_addr_o, pc_new_o, sp_new_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  irq_entry_seq uut (.*);

  logic [15:0] mem [0:511];
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o[9:1]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[9:1]];
  end

  function automatic logic [15:0] vec_hi(input int l);
    return 16'h00C0 + 16'(l);
  endfunction
  function automatic logic [15:0] vec_lo(input int l);
    return 16'h1230 + 16'(l * 16);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {level[8:6], im[5], mask[4:2], trace[1], accept[0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {3'd3, 1'b1, 3'd0, 1'b0, 1'b1},
    {3'd5, 1'b0, 3'd4, 1'b0, 1'b1},
    {3'd4, 1'b1, 3'd4, 1'b0, 1'b0},
    {3'd2, 1'b1, 3'd5, 1'b1, 1'b0},
    {3'd7, 1'b1, 3'd6, 1'b1, 1'b1},
    {3'd0, 1'b1, 3'd0, 1'b0, 1'b0},
    {3'd1, 1'b0, 3'd0, 1'b1, 1'b1},
    {3'd7, 1'b1, 3'd7, 1'b0, 1'b0}
  };

  task automatic run_case(input int idx, input logic [8:0] v);
    logic [2:0]  lvl  = v[8:6];
    logic        im   = v[5];
    logic [2:0]  msk  = v[4:2];
    logic        tr   = v[1];
    logic        acc  = v[0];
    logic [15:0] sr   = {tr, 2'b00, 2'b00, msk, 8'h5A};
    logic [31:0] pc   = 32'h0012_3400 + 32'(idx * 16);
    logic [31:0] sp   = 32'h0000_0300 - 32'(idx * 32);
    logic [15:0] exp_sr = {1'b0, 1'b0, 1'b1, 2'b00, (im ? lvl : 3'd7), 8'h5A};
    int acks = 0, strobes = 0, busy_n = 0, ack_k = 0, done_k = 0, ord_bad = 0;
    logic [31:0] ack_addr = '0, pcn = '0, spn = '0;
    logic [15:0] srn = '0;
    @(negedge clk_i);
    irq_level_i = lvl; mask_ctl_i = im; sr_i = sr; pc_next_i = pc; sp_i = sp;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      if (ack_o) begin acks++; ack_k = k; ack_addr = mem_addr_o; end
      if (sr_we_o) srn = sr_new_o;
      if (busy_o) busy_n++;
      if (mem_we_o || mem_re_o || ack_o) strobes++;
      if (k >= 2 && k <= 5)
        if (!(mem_we_o && mem_addr_o == sp - 32'(2 * (k - 1)))) ord_bad++;
      if (k == 6 && !(mem_re_o && mem_addr_o == 32'(4 * (24 + lvl)))) ord_bad++;
      if (k == 7 && !(mem_re_o && mem_addr_o == 32'(4 * (24 + lvl) + 2))) ord_bad++;
      if (done_o) begin done_k = k; pcn = pc_new_o; spn = sp_new_o; end
      if (k == 9) irq_level_i = '0;
    end
    irq_level_i = '0;
    if (!acc) begin
      chk(strobes == 0 && busy_n == 0, "R1", "rejected request strobes", 32'(strobes + busy_n), 0);
      if (lvl == 3'd7) chk(acks == 0, "R9", "level 7 under mask 7", 32'(acks), 0);
    end else begin
      chk(ack_k == 1 && ack_addr == {28'h0, lvl, 1'b0}, "R2", "ack cycle/address",
          {ack_k[7:0], ack_addr[23:0]}, {8'd1, 20'h0, lvl, 1'b0});
      chk(srn == exp_sr, "R3", "new status", 32'(srn), 32'(exp_sr));
      chk(mem[(sp - 8) >> 1] == sr, "R4", "saved status", 32'(mem[(sp - 8) >> 1]), 32'(sr));
      chk(mem[(sp - 2) >> 1] == 16'(4 * (24 + lvl)), "R5", "format word",
          32'(mem[(sp - 2) >> 1]), 32'(4 * (24 + lvl)));
      chk({mem[(sp - 6) >> 1], mem[(sp - 4) >> 1]} == pc, "R5", "stacked pc",
          {mem[(sp - 6) >> 1], mem[(sp - 4) >> 1]}, pc);
      chk(ord_bad == 0, "R6", "access order/addresses", 32'(ord_bad), 0);
      chk(done_k == 9 && pcn == {vec_hi(lvl), vec_lo(lvl)}, "R7", "done cycle/handler",
          pcn, {vec_hi(lvl), vec_lo(lvl)});
      chk(spn == sp - 8, "R7", "new stack pointer", spn, sp - 8);
      chk(acks == 1 && busy_n == 9, "R8", "single ack while busy", 32'(acks * 16 + busy_n), 32'h19);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int l = 1; l < 8; l++) begin
      mem[(4 * (24 + l)) / 2]     = vec_hi(l);
      mem[(4 * (24 + l)) / 2 + 1] = vec_lo(l);
    end
    repeat (3) @(negedge clk_i);
    chk({busy_o, ack_o, sr_we_o, mem_we_o, mem_re_o, done_o} == 6'b0, "R10",
        "reset outputs", 32'({busy_o, ack_o, sr_we_o, mem_we_o, mem_re_o, done_o}), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) run_case(i, VEC[i]);

    // reset in the middle of a sequence
    @(negedge clk_i);
    irq_level_i = 3'd6; sr_i = 16'h0000; sp_i = 32'h200; pc_next_i = 32'h40;
    repeat (4) @(negedge clk_i);
    irq_level_i = '0;
    rst_ni = 1'b0;
    #1;
    chk({busy_o, ack_o, sr_we_o, mem_we_o, mem_re_o, done_o} == 6'b0, "R10",
        "mid-sequence reset", 32'({busy_o, ack_o, sr_we_o, mem_we_o, mem_re_o, done_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o, "R10", "idle after reset release", 32'({busy_o, done_o}), 0);

    // equal level rejected with nonzero mask, then level above accepted
    run_case(8, {3'd2, 1'b1, 3'd2, 1'b0, 1'b0});
    run_case(9, {3'd7, 1'b0, 3'd3, 1'b1, 1'b1});

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule